// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block is the noise voice of a sound unit. A 15-stage linear feedback shift register is stepped by a programmable timer. Its lowest stage decides, sample by sample, whether the voice puts out its current envelope volume or silence. A mode bit shortens the register to 7 effective stages. The shorter sequence repeats quickly enough to sound tonal instead of hissy.

Software-style configuration arrives as write strobes carrying field values. These set the shift rate (a divisor code and a shift code), the width mode, the envelope settings and a length load. A control write carries a start strobe and a length-enable bit. Two slow strobes come from an external frame sequencer: one at the length rate (256 Hz) and one at the envelope rate (64 Hz). The voice puts out a 4-bit digital sample and a flag that shows whether it is sounding. Conversion to analog and mixing with other voices happen elsewhere.

Top module: `noise_channel`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `active` is 0 and `sample` is 0. The register holds all ones.
- R2: A start (a control write with `ctl_trig`=1) sets `active` on the next clock, provided the output stage is powered, and loads all ones into the register. While bit 0 stays 1, `sample` reads 0.
- R3: On each step, the new bit 14 is bit 0 XOR bit 1, and the other bits shift down by one place. When `poly_narrow`=1, the same feedback bit is also written into bit 6.
- R4: Steps are spaced P clock cycles apart. P = (`poly_div`=0 ? BASE_DIV : 2·BASE_DIV·`poly_div`) << `poly_shift`. A start restarts the spacing, so the first step comes P cycles after the start. A rate change takes effect at the next reload.
- R5: When `poly_shift` is 14 or 15, the register never steps.
- R6: A length load of t sets a count of 64−t. With the length enable set, each length tick decrements the count, and reaching zero clears `active`. With the enable clear, ticks leave the count and `active` alone.
- R7: A start loads the envelope volume from `env_init`. Every `env_period` envelope ticks, the volume moves one step up (`env_up`=1) or down. It saturates at 15 and at 0. A period of 0 freezes it. A volume of 0 does not clear `active`.
- R8: The output stage is powered when `env_init`≠0 or `env_up`=1. When it is unpowered, `active` goes to 0 one cycle after the setting is held, and a start cannot set it.
- R9: `sample` equals the envelope volume when `active`=1 and register bit 0 is 0. Otherwise it is 0.
- R10: A start takes precedence over length and envelope ticks in the same cycle, and those ticks are dropped. A start that finds the length count at zero reloads it to 64.
- R11: A length load replaces the count at any time, even while the voice is sounding, and it wins over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| len_wr | input | 1 | Length load strobe |
| len_val | input | 6 | Length load value t |
| env_wr | input | 1 | Envelope settings write strobe |
| env_init | input | 4 | Starting volume |
| env_up | input | 1 | Envelope direction, 1 = rising |
| env_period | input | 3 | Envelope ticks per step, 0 = frozen |
| poly_wr | input | 1 | Rate and mode write strobe |
| poly_shift | input | 4 | Rate shift code |
| poly_narrow | input | 1 | 1 = 7-stage mode |
| poly_div | input | 3 | Rate divisor code |
| ctl_wr | input | 1 | Control write strobe |
| ctl_trig | input | 1 | Start request, used with `ctl_wr` |
| ctl_len_en | input | 1 | Length enable, stored on `ctl_wr` |
| tick_len | input | 1 | Length-rate strobe |
| tick_env | input | 1 | Envelope-rate strobe |
| sample | output | 4 | Digital output sample |
| active | output | 1 | Voice sounding flag |

## Verification
The start strobe can land in the same cycle as a length tick and an envelope tick. The bench provokes this by first letting the length count run out, then issuing a start with both ticks pulsed together. It judges the result by counting length ticks: the voice must fall silent on exactly the 64th tick and not one earlier. A cycle-accurate behavioural model, compared on every clock, also confirms that the envelope volume after the collision is the fresh starting value.

// File: rtl/noise_pkg.sv
package noise_pkg;
    localparam int VOL_BITS   = 4;
    localparam int LFSR_W     = 15;
    localparam int NARROW_TAP = 6;
    localparam int SHIFT_BITS = 4;
    localparam int DIV_BITS   = 3;
    localparam int PER_BITS   = 3;
    localparam int STALL_CODE = 14;

    typedef logic [VOL_BITS-1:0] vol_t;
    typedef logic [LFSR_W-1:0]   lfsr_t;

    typedef struct packed {
        vol_t                init;
        logic                up;
        logic [PER_BITS-1:0] per;
    } env_cfg_t;

    typedef struct packed {
        logic [SHIFT_BITS-1:0] shift;
        logic                  narrow;
        logic [DIV_BITS-1:0]   div;
    } poly_cfg_t;

    localparam lfsr_t LFSR_SEED = '1;
endpackage

// File: rtl/noise_lfsr_timer.sv
module noise_lfsr_timer
    import noise_pkg::*;
#(
    parameter int BASE_DIV = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trig,
    input  poly_cfg_t cfg,
    output lfsr_t     lfsr
);
    localparam int CNT_W = $clog2(2 * BASE_DIV * ((1 << DIV_BITS) - 1) + 1)
                           + (1 << SHIFT_BITS) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        lfsr_t            lfsr;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CNT_W-1:0] base, period;
    logic             stall;
    logic             fb;
    lfsr_t            stepped;

    always_comb begin
        st_d    = st_q;
        base    = (cfg.div == '0) ? CNT_W'(BASE_DIV)
                                  : CNT_W'(2 * BASE_DIV) * CNT_W'(cfg.div);
        period  = base << cfg.shift;
        stall   = (cfg.shift >= SHIFT_BITS'(STALL_CODE));
        fb      = st_q.lfsr[0] ^ st_q.lfsr[1];
        stepped = {fb, st_q.lfsr[LFSR_W-1:1]};
        if (cfg.narrow) begin
            stepped[NARROW_TAP] = fb;
        end
        if (trig) begin
            st_d.lfsr = LFSR_SEED;
            st_d.cnt  = period;
        end else if (st_q.cnt <= CNT_W'(1)) begin
            st_d.cnt = period;
            if (!stall) begin
                st_d.lfsr = stepped;
            end
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.lfsr <= LFSR_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign lfsr = st_q.lfsr;
endmodule

// File: rtl/noise_length.sv
module noise_length #(
    parameter int LEN_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                len_wr,
    input  logic [LEN_BITS-1:0] len_val,
    input  logic                trig,
    input  logic                tick,
    input  logic                en,
    output logic                expire
);
    localparam int CW = LEN_BITS + 1;
    localparam logic [CW-1:0] FULL = {1'b1, {LEN_BITS{1'b0}}};

    typedef struct packed {
        logic [CW-1:0] cnt;
    } len_state_t;

    len_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (len_wr) begin
            st_d.cnt = FULL - {1'b0, len_val};
        end else if (trig) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = FULL;
            end
        end else if (tick && en && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CW'(1);
            expire   = (st_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/noise_envelope.sv
module noise_envelope
    import noise_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     trig,
    input  logic     tick,
    input  env_cfg_t cfg,
    output vol_t     vol
);
    typedef struct packed {
        vol_t                vol;
        logic [PER_BITS-1:0] timer;
    } env_state_t;

    env_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d.vol   = cfg.init;
            st_d.timer = cfg.per;
        end else if (tick && (cfg.per != '0)) begin
            if (st_q.timer <= PER_BITS'(1)) begin
                st_d.timer = cfg.per;
                if (cfg.up && (st_q.vol != '1)) begin
                    st_d.vol = st_q.vol + VOL_BITS'(1);
                end else if (!cfg.up && (st_q.vol != '0)) begin
                    st_d.vol = st_q.vol - VOL_BITS'(1);
                end
            end else begin
                st_d.timer = st_q.timer - PER_BITS'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vol   <= '0;
            st_q.timer <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vol = st_q.vol;
endmodule

// File: rtl/noise_channel.sv
module noise_channel
    import noise_pkg::*;
#(
    parameter int BASE_DIV = 8,
    parameter int LEN_BITS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  len_wr,
    input  logic [LEN_BITS-1:0]   len_val,
    input  logic                  env_wr,
    input  logic [VOL_BITS-1:0]   env_init,
    input  logic                  env_up,
    input  logic [PER_BITS-1:0]   env_period,
    input  logic                  poly_wr,
    input  logic [SHIFT_BITS-1:0] poly_shift,
    input  logic                  poly_narrow,
    input  logic [DIV_BITS-1:0]   poly_div,
    input  logic                  ctl_wr,
    input  logic                  ctl_trig,
    input  logic                  ctl_len_en,
    input  logic                  tick_len,
    input  logic                  tick_env,
    output logic [VOL_BITS-1:0]   sample,
    output logic                  active
);
    typedef struct packed {
        env_cfg_t  env;
        poly_cfg_t poly;
        logic      len_en;
        logic      active;
    } top_state_t;

    top_state_t st_d, st_q;
    logic  trig_w, dac_on_w, len_expire_w;
    lfsr_t lfsr_w;
    vol_t  vol_w;
    logic [SHIFT_BITS-1:0] shift_code_w;
    logic [PER_BITS-1:0]   env_per_w;

    assign trig_w       = ctl_wr & ctl_trig;
    assign dac_on_w     = (st_q.env.init != '0) | st_q.env.up;
    assign shift_code_w = st_q.poly.shift;
    assign env_per_w    = st_q.env.per;

    noise_lfsr_timer #(.BASE_DIV(BASE_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig_w),
        .cfg   (st_q.poly),
        .lfsr  (lfsr_w)
    );

    noise_length #(.LEN_BITS(LEN_BITS)) u_length (
        .clk     (clk),
        .rst_n   (rst_n),
        .len_wr  (len_wr),
        .len_val (len_val),
        .trig    (trig_w),
        .tick    (tick_len),
        .en      (st_q.len_en),
        .expire  (len_expire_w)
    );

    noise_envelope u_env (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig_w),
        .tick  (tick_env),
        .cfg   (st_q.env),
        .vol   (vol_w)
    );

    always_comb begin
        st_d = st_q;
        if (env_wr) begin
            st_d.env.init = env_init;
            st_d.env.up   = env_up;
            st_d.env.per  = env_period;
        end
        if (poly_wr) begin
            st_d.poly.shift  = poly_shift;
            st_d.poly.narrow = poly_narrow;
            st_d.poly.div    = poly_div;
        end
        if (ctl_wr) begin
            st_d.len_en = ctl_len_en;
        end
        st_d.active = (trig_w | st_q.active) & ~len_expire_w & dac_on_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign sample = (st_q.active && !lfsr_w[0]) ? vol_w : '0;
endmodule

// File: rtl/noise_channel_checker.sv
module noise_channel_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       trig,
    input logic       dac_on,
    input logic       len_expire,
    input logic       active,
    input logic [3:0] sample,
    input logic [14:0] lfsr,
    input logic [3:0] shift_code,
    input logic [2:0] env_per,
    input logic [3:0] vol
);
    // R1: held reset leaves the voice silent on the following edge
    a_r1_reset_silent: assert property (@(posedge clk)
        !rst_n |=> (!active && sample == 4'd0));

    // R2: a start with the stage powered raises the flag
    a_r2_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && dac_on) |=> active);

    // R5: high shift codes freeze the register
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_code >= 4'd14 && !trig) |=> $stable(lfsr));

    // R6: length expiry silences the voice
    a_r6_expire_clears: assert property (@(posedge clk) disable iff (!rst_n)
        len_expire |=> !active);

    // R7: a zero envelope period holds the volume
    a_r7_env_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (env_per == 3'd0 && !trig) |=> $stable(vol));

    // R8: unpowered stage forces the flag low
    a_r8_dac_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_on |=> !active);

    // R9: an idle voice outputs zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (sample == 4'd0));
endmodule

bind noise_channel noise_channel_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig_w),
    .dac_on     (dac_on_w),
    .len_expire (len_expire_w),
    .active     (active),
    .sample     (sample),
    .lfsr       (lfsr_w),
    .shift_code (shift_code_w),
    .env_per    (env_per_w),
    .vol        (vol_w)
);

// File: tb/noise_channel_test.sv
`timescale 1ns/1ps
module noise_channel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       len_wr = 0, env_wr = 0, env_up = 0, poly_wr = 0, poly_narrow = 0;
    logic       ctl_wr = 0, ctl_trig = 0, ctl_len_en = 0, tick_len = 0, tick_env = 0;
    logic [5:0] len_val = '0;
    logic [3:0] env_init = '0, poly_shift = '0;
    logic [2:0] env_period = '0, poly_div = '0;
    logic [3:0] sample;
    logic       active;

    int checks = 0, failures = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    noise_channel uut (
        .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_val(len_val),
        .env_wr(env_wr), .env_init(env_init), .env_up(env_up), .env_period(env_period),
        .poly_wr(poly_wr), .poly_shift(poly_shift), .poly_narrow(poly_narrow),
        .poly_div(poly_div), .ctl_wr(ctl_wr), .ctl_trig(ctl_trig),
        .ctl_len_en(ctl_len_en), .tick_len(tick_len), .tick_env(tick_env),
        .sample(sample), .active(active)
    );

    // behavioural reference model
    int m_lfsr = 'h7FFF, m_cnt = 0, m_lcnt = 0, m_vol = 0, m_et = 0, m_act = 0;
    int m_init = 0, m_up = 0, m_per = 0, m_s = 0, m_nar = 0, m_r = 0, m_len_en = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lfsr = 'h7FFF; m_cnt = 0; m_lcnt = 0; m_vol = 0; m_et = 0; m_act = 0;
            m_init = 0; m_up = 0; m_per = 0; m_s = 0; m_nar = 0; m_r = 0; m_len_en = 0;
        end else begin
            int trig, dac, period, nl, nc, nlc, nv, ne, expire, fb;
            trig   = ctl_wr && ctl_trig;
            dac    = (m_init != 0) || (m_up != 0);
            period = ((m_r == 0) ? 8 : 16 * m_r) << m_s;
            nl = m_lfsr; nc = m_cnt; nlc = m_lcnt; nv = m_vol; ne = m_et; expire = 0;
            if (trig) begin
                nl = 'h7FFF; nc = period;
            end else if (m_cnt <= 1) begin
                nc = period;
                if (m_s < 14) begin
                    fb = (m_lfsr ^ (m_lfsr >> 1)) & 1;
                    nl = (m_lfsr >> 1) | (fb << 14);
                    if (m_nar != 0) nl = (nl & ~(1 << 6)) | (fb << 6);
                end
            end else nc = m_cnt - 1;
            if (len_wr) nlc = 64 - len_val;
            else if (trig) begin
                if (m_lcnt == 0) nlc = 64;
            end else if (tick_len && m_len_en != 0 && m_lcnt != 0) begin
                nlc = m_lcnt - 1; expire = (nlc == 0);
            end
            if (trig) begin
                nv = m_init; ne = m_per;
            end else if (tick_env && m_per != 0) begin
                if (m_et <= 1) begin
                    ne = m_per;
                    if (m_up != 0 && m_vol < 15) nv = m_vol + 1;
                    else if (m_up == 0 && m_vol > 0) nv = m_vol - 1;
                end else ne = m_et - 1;
            end
            m_act = ((trig || m_act != 0) && !expire && dac) ? 1 : 0;
            m_lfsr = nl; m_cnt = nc; m_lcnt = nlc; m_vol = nv; m_et = ne;
            if (env_wr) begin m_init = env_init; m_up = env_up; m_per = env_period; end
            if (poly_wr) begin m_s = poly_shift; m_nar = poly_narrow; m_r = poly_div; end
            if (ctl_wr) m_len_en = ctl_len_en;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp;
            exp = (m_act != 0 && (m_lfsr & 1) == 0) ? m_vol : 0;
            chk(sample == exp, cur_req, "sample", sample, exp);
            chk(active == m_act, cur_req, "active", active, m_act);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr_env(int i, bit up, int p);
        @(negedge clk); env_wr = 1; env_init = i[3:0]; env_up = up; env_period = p[2:0];
        @(negedge clk); env_wr = 0;
    endtask
    task automatic wr_poly(int s, bit nar, int r);
        @(negedge clk); poly_wr = 1; poly_shift = s[3:0]; poly_narrow = nar; poly_div = r[2:0];
        @(negedge clk); poly_wr = 0;
    endtask
    task automatic wr_len(int t);
        @(negedge clk); len_wr = 1; len_val = t[5:0];
        @(negedge clk); len_wr = 0;
    endtask
    task automatic start(bit en, bit lt, bit et);
        @(negedge clk); ctl_wr = 1; ctl_trig = 1; ctl_len_en = en; tick_len = lt; tick_env = et;
        @(negedge clk); ctl_wr = 0; ctl_trig = 0; tick_len = 0; tick_env = 0;
    endtask
    task automatic ticks(int n, int gap, bit lt, bit et);
        repeat (n) begin
            idle(gap);
            tick_len = lt; tick_env = et;
            @(negedge clk); tick_len = 0; tick_env = 0;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 5.0);
        checks++; failures++;
        $display("FAIL watchdog run hung actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        chk(active == 0 && sample == 0, "R1", "in reset", active, 0);
        rst_n = 1;
        @(negedge clk);
        chk(active == 0 && sample == 0, "R1", "after release", sample, 0);

        cur_req = "R2";
        wr_env(12, 0, 0);
        wr_poly(0, 0, 0);
        start(0, 0, 0);
        chk(active == 1, "R2", "active after start", active, 1);
        chk(sample == 0, "R2", "sample after start", sample, 0);

        cur_req = "R4"; idle(400);
        cur_req = "R9"; ticks(5, 7, 1, 1);

        cur_req = "R3"; wr_poly(1, 1, 1); start(0, 0, 0); idle(1500);
        cur_req = "R4"; wr_poly(2, 0, 3); idle(800);

        cur_req = "R5";
        wr_poly(15, 0, 0); idle(5);
        begin
            int held;
            held = sample;
            idle(300);
            chk(sample == held, "R5", "frozen sample", sample, held);
        end
        wr_poly(14, 1, 2); idle(200);

        cur_req = "R7";
        wr_poly(0, 0, 0);
        wr_env(3, 1, 2); start(0, 0, 0); ticks(30, 5, 0, 1); idle(100);
        wr_env(1, 0, 1); start(0, 0, 0); ticks(1, 3, 0, 1);
        chk(active == 1, "R7", "active at zero volume", active, 1);
        idle(100);

        cur_req = "R6";
        wr_env(9, 0, 0);
        wr_len(60); start(1, 0, 0);
        ticks(3, 4, 1, 0);
        chk(active == 1, "R6", "active before expiry", active, 1);
        ticks(1, 4, 1, 0);
        chk(active == 0, "R6", "expired", active, 0);
        wr_len(62); start(0, 0, 0);
        ticks(5, 4, 1, 0);
        chk(active == 1, "R6", "length disabled", active, 1);

        cur_req = "R11";
        start(1, 0, 0);
        wr_len(63);
        ticks(1, 4, 1, 0);
        chk(active == 0, "R11", "reloaded length expiry", active, 0);

        cur_req = "R10";
        wr_env(5, 1, 1);
        start(1, 1, 1);
        ticks(63, 3, 1, 1);
        chk(active == 1, "R10", "active after 63 ticks", active, 1);
        ticks(1, 3, 1, 0);
        chk(active == 0, "R10", "silent on 64th tick", active, 0);

        cur_req = "R8";
        start(0, 0, 0);
        wr_env(0, 0, 0);
        idle(1);
        chk(active == 0, "R8", "unpowered clears", active, 0);
        start(0, 0, 0);
        chk(active == 0, "R8", "start ignored unpowered", active, 0);
        idle(20);

        finish_run();
    end
endmodule